// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block sits at the top of the interrupt tree of a USB device controller. It takes five groups of interrupt causes: the serial interface engine, the general endpoints, DMA, FIFO and endpoint 0. Each group arrives as a status vector and an enable vector. The block reduces each group to a single summary bit. It also holds one latched cause of its own, which records that a control SETUP packet has been fully captured. The summaries and the SETUP flag together form an 8-bit main status register. An 8-bit main enable register selects which status bits may drive the active-low interrupt line.

Both registers sit behind a simple CPU register port. The port has a single-cycle write strobe and a combinational read multiplexer, and a small offset selects the register: offset 0 is status, offset 1 is enable, and any other offset reads as zero.

When a SETUP capture is signalled, the block also rewrites the endpoint-0 handshake controls for both directions in the same clock edge, so that the new control transfer starts from a known state. At other times those controls are loaded from a separate control write port.

Top module: `usb_irq_aggregator`

## Requirements
- R1: Main status reads, at offset 0, as follows. Bit 7 is 1 exactly when the serial engine status ANDed with its enable is nonzero. Bit 6 does the same for the general endpoint group, bit 5 for DMA, bit 4 for FIFO and bit 1 for endpoint 0. Bit 0 is the latched SETUP flag.
- R2: Bits 3:2 read as 0 in both the status register and the enable register, at all times.
- R3: A CPU write to the status offset has no effect on bits 7:1. Those bits keep following their group inputs.
- R4: A one-cycle pulse on `setup_done` sets status bit 0, which is visible after that clock edge.
- R5: A status write with data bit 0 equal to 1 clears status bit 0 at the next edge. A write with data bit 0 equal to 0 leaves it unchanged.
- R6: If `setup_done` and a write-1-to-clear of bit 0 happen in the same cycle, bit 0 ends up set.
- R7: On the edge where `setup_done` is high, both endpoint-0 control fields, each laid out as {stall, nak, toggle}, become 3'b011. This takes priority over a control load in the same cycle.
- R8: With `setup_done` low, a pulse on `ep0_ctl_ld` loads `ep0_ctl_wdata` into the controls, with bits [5:3] going to IN and bits [2:0] going to OUT. Without a load, the controls hold their value.
- R9: `irq_n` is 0 exactly when some main status bit and its matching enable bit are both 1. Otherwise it is 1.
- R10: A write at offset 1 stores the data into the enable register with bits 3:2 forced to 0. The enable register reads back at offset 1.
- R11: Under reset, the SETUP flag, the enable register and both control fields are 0, and `irq_n` is 1.
- R12: The serial engine summary bit and `irq_n` follow their inputs combinationally. A change takes effect without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sie_stat | input | SIE_W | Serial engine cause vector |
| sie_en | input | SIE_W | Serial engine enable vector |
| epr_stat | input | EPR_W | General endpoint cause vector |
| epr_en | input | EPR_W | General endpoint enable vector |
| dma_stat | input | DMA_W | DMA cause vector |
| dma_en | input | DMA_W | DMA enable vector |
| fifo_stat | input | FIFO_W | FIFO cause vector |
| fifo_en | input | FIFO_W | FIFO enable vector |
| ep0_stat | input | EP0_W | Endpoint-0 cause vector |
| ep0_en | input | EP0_W | Endpoint-0 enable vector |
| setup_done | input | 1 | Pulse: SETUP bytes fully stored |
| ep0_ctl_ld | input | 1 | Load strobe for endpoint-0 controls |
| ep0_ctl_wdata | input | 6 | {IN stall,nak,toggle, OUT stall,nak,toggle} |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_n | output | 1 | Active-low interrupt |
| ep0_in_ctl | output | 3 | IN control {stall, nak, toggle} |
| ep0_out_ctl | output | 3 | OUT control {stall, nak, toggle} |

## Verification
Random group vectors are built by ANDing two random words. This gives sparse masks, so every summary bit is seen both with overlapping and with disjoint status and enable bits, which separates a true AND-reduction from an OR or a plain copy of either vector. Random offsets, writes and SETUP pulses exercise the two registers and the interrupt line against a bench model. Directed cases force the orderings that random traffic rarely produces: capture and clear in the same cycle, capture and control load in the same cycle, a write of all ones to the status offset, and a change of the serial engine inputs between clock edges.

// File: rtl/usb_irq_aggregator.sv
`timescale 1ns/1ps
module usb_irq_aggregator #(
  parameter int SIE_W  = 8,
  parameter int EPR_W  = 8,
  parameter int DMA_W  = 4,
  parameter int FIFO_W = 4,
  parameter int EP0_W  = 6,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIE_W-1:0]  sie_stat,
  input  logic [SIE_W-1:0]  sie_en,
  input  logic [EPR_W-1:0]  epr_stat,
  input  logic [EPR_W-1:0]  epr_en,
  input  logic [DMA_W-1:0]  dma_stat,
  input  logic [DMA_W-1:0]  dma_en,
  input  logic [FIFO_W-1:0] fifo_stat,
  input  logic [FIFO_W-1:0] fifo_en,
  input  logic [EP0_W-1:0]  ep0_stat,
  input  logic [EP0_W-1:0]  ep0_en,
  input  logic              setup_done,
  input  logic              ep0_ctl_ld,
  input  logic [5:0]        ep0_ctl_wdata,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_n,
  output logic [2:0]        ep0_in_ctl,
  output logic [2:0]        ep0_out_ctl
);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(1);
  localparam logic [7:0]        EN_MASK  = 8'hF3;
  localparam logic [2:0]        CTL_SETUP = 3'b011;

  logic       setup_q;
  logic [7:0] en_q;
  logic [5:0] ctl_q;

  wire sum_sie  = |(sie_stat & sie_en);
  wire sum_epr  = |(epr_stat & epr_en);
  wire sum_dma  = |(dma_stat & dma_en);
  wire sum_fifo = |(fifo_stat & fifo_en);
  wire sum_ep0  = |(ep0_stat & ep0_en);

  wire [7:0] main_stat = {sum_sie, sum_epr, sum_dma, sum_fifo, 2'b00, sum_ep0, setup_q};

  wire wr_stat = reg_wr && (reg_addr == OFS_STAT);
  wire wr_en   = reg_wr && (reg_addr == OFS_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        setup_q <= 1'b0;
    else if (setup_done)               setup_q <= 1'b1;
    else if (wr_stat && reg_wdata[0])  setup_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 8'h00;
    else if (wr_en) en_q <= reg_wdata & EN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctl_q <= 6'd0;
    else if (setup_done) ctl_q <= {CTL_SETUP, CTL_SETUP};
    else if (ep0_ctl_ld) ctl_q <= ep0_ctl_wdata;
  end

  assign reg_rdata   = (reg_addr == OFS_STAT) ? main_stat :
                       (reg_addr == OFS_EN)   ? en_q      : 8'h00;
  assign irq_n       = ~|(main_stat & en_q);
  assign ep0_in_ctl  = ctl_q[5:3];
  assign ep0_out_ctl = ctl_q[2:0];

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3:2] == 2'b00);

  assert_setup_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> reg_addr != OFS_STAT || reg_rdata[0]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[0] && !setup_done) |=> !setup_q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_done && !(wr_stat && reg_wdata[0])) |=> $stable(setup_q));

  assert_capture_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && wr_stat && reg_wdata[0]) |=> setup_q);

  assert_ctl_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> (ep0_in_ctl == CTL_SETUP && ep0_out_ctl == CTL_SETUP));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_done && !ep0_ctl_ld) |=> ($stable(ep0_in_ctl) && $stable(ep0_out_ctl)));

  assert_en_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == ($past(reg_wdata) & EN_MASK));
endmodule

// File: tb/tb_usb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_usb_irq_aggregator;
  logic clk = 0, rst_n = 0;
  logic [7:0] sie_stat, sie_en, epr_stat, epr_en;
  logic [3:0] dma_stat, dma_en, fifo_stat, fifo_en;
  logic [5:0] ep0_stat, ep0_en;
  logic setup_done, ep0_ctl_ld, reg_wr;
  logic [5:0] ep0_ctl_wdata;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq_n;
  logic [2:0] ep0_in_ctl, ep0_out_ctl;

  int checks = 0, errors = 0;
  bit m_setup = 0;
  logic [7:0] m_en = 0;
  logic [5:0] m_ctl = 0;
  string ctl_tag = "R11";
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_irq_aggregator dut (.*);

  function automatic logic [7:0] exp_stat();
    return {|(sie_stat & sie_en), |(epr_stat & epr_en), |(dma_stat & dma_en),
            |(fifo_stat & fifo_en), 2'b00, |(ep0_stat & ep0_en), m_setup};
  endfunction

  function automatic logic [7:0] exp_rd();
    case (reg_addr)
      2'd0: return exp_stat();
      2'd1: return m_en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sie_stat = 0; sie_en = 0; epr_stat = 0; epr_en = 0; dma_stat = 0; dma_en = 0;
    fifo_stat = 0; fifo_en = 0; ep0_stat = 0; ep0_en = 0;
    setup_done = 0; ep0_ctl_ld = 0; ep0_ctl_wdata = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic check_all();
    chk(reg_rdata === exp_rd(), reg_addr == 1 ? "R10" : "R1", reg_rdata, exp_rd());
    chk(irq_n === ~|(exp_stat() & m_en), "R9", irq_n, ~|(exp_stat() & m_en));
    chk({ep0_in_ctl, ep0_out_ctl} === m_ctl, ctl_tag, {ep0_in_ctl, ep0_out_ctl}, m_ctl);
  endtask

  task automatic cycle();
    #1 check_all();
    @(posedge clk);
    if (setup_done) m_setup = 1;
    else if (reg_wr && reg_addr == 0 && reg_wdata[0]) m_setup = 0;
    if (reg_wr && reg_addr == 1) m_en = reg_wdata & 8'hF3;
    if (setup_done) begin m_ctl = 6'b011011; ctl_tag = "R7"; end
    else if (ep0_ctl_ld) begin m_ctl = ep0_ctl_wdata; ctl_tag = "R8"; end
    @(negedge clk);
  endtask

  task automatic randomize_inputs();
    sie_stat = $urandom & $urandom; sie_en = $urandom & $urandom;
    epr_stat = $urandom & $urandom; epr_en = $urandom & $urandom;
    dma_stat = $urandom & $urandom; dma_en = $urandom & $urandom;
    fifo_stat = $urandom & $urandom; fifo_en = $urandom & $urandom;
    ep0_stat = $urandom & $urandom; ep0_en = $urandom & $urandom;
    setup_done = ($urandom % 8) == 0;
    ep0_ctl_ld = ($urandom % 4) == 0;
    ep0_ctl_wdata = $urandom;
    reg_wr = ($urandom % 3) == 0;
    reg_addr = $urandom;
    reg_wdata = $urandom;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    idle();
    #12;
    // R11: reset state
    reg_addr = 1; #1;
    chk(reg_rdata === 8'h00 && irq_n === 1'b1, "R11", {reg_rdata, irq_n}, 9'h001);
    chk({ep0_in_ctl, ep0_out_ctl} === 6'd0, "R11", {ep0_in_ctl, ep0_out_ctl}, 0);
    reg_addr = 0; #1;
    chk(reg_rdata === 8'h00, "R11", reg_rdata, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R12: serial engine summary with no clock edge in between
    sie_stat = 8'h10; sie_en = 8'h10; reg_addr = 0; #0.5;
    chk(reg_rdata[7] === 1'b1, "R12", reg_rdata[7], 1);
    sie_stat = 8'h00; #0.5;
    chk(reg_rdata[7] === 1'b0, "R12", reg_rdata[7], 0);
    @(negedge clk);

    // R10/R2: enable all ones reads back with 3:2 cleared
    reg_wr = 1; reg_addr = 1; reg_wdata = 8'hFF; cycle();
    reg_wr = 0; #1;
    chk(reg_rdata === 8'hF3, "R10", reg_rdata, 8'hF3);
    chk(reg_rdata[3:2] === 2'b00, "R2", reg_rdata[3:2], 0);

    // R4: setup sets bit 0, R7 controls forced, R9 irq
    reg_addr = 0; setup_done = 1; cycle(); setup_done = 0; #1;
    chk(reg_rdata[0] === 1'b1, "R4", reg_rdata[0], 1);
    chk({ep0_in_ctl, ep0_out_ctl} === 6'b011011, "R7", {ep0_in_ctl, ep0_out_ctl}, 6'b011011);
    chk(irq_n === 1'b0, "R9", irq_n, 0);

    // R5: write 0 keeps, write 1 clears
    reg_wr = 1; reg_wdata = 8'h00; cycle(); reg_wr = 0; #1;
    chk(reg_rdata[0] === 1'b1, "R5", reg_rdata[0], 1);
    reg_wr = 1; reg_wdata = 8'h01; cycle(); reg_wr = 0; #1;
    chk(reg_rdata[0] === 1'b0 && irq_n === 1'b1, "R5", {reg_rdata[0], irq_n}, 2'b01);

    // R3: writing ones to status leaves summaries tied to inputs
    epr_stat = 8'h02; epr_en = 8'h02; dma_stat = 4'h1; dma_en = 4'h2;
    reg_wr = 1; reg_wdata = 8'hFF; cycle(); reg_wr = 0;
    epr_stat = 8'h00; dma_stat = 4'h2; #1;
    chk(reg_rdata === 8'h20, "R3", reg_rdata, 8'h20);
    epr_stat = 0; epr_en = 0; dma_stat = 0; dma_en = 0;

    // R6: capture and clear in the same cycle
    setup_done = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'h01; cycle();
    setup_done = 0; reg_wr = 0; #1;
    chk(reg_rdata[0] === 1'b1, "R6", reg_rdata[0], 1);

    // R8: load, then setup beats load
    ep0_ctl_ld = 1; ep0_ctl_wdata = 6'b100100; cycle(); ep0_ctl_ld = 0; #1;
    chk({ep0_in_ctl, ep0_out_ctl} === 6'b100100, "R8", {ep0_in_ctl, ep0_out_ctl}, 6'b100100);
    ep0_ctl_ld = 1; ep0_ctl_wdata = 6'b100100; setup_done = 1; cycle();
    ep0_ctl_ld = 0; setup_done = 0; #1;
    chk({ep0_in_ctl, ep0_out_ctl} === 6'b011011, "R7", {ep0_in_ctl, ep0_out_ctl}, 6'b011011);
    @(negedge clk);

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      cycle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule